// File: doc/BRIEF.md
# Oscillator trim binary-search calibrator

This block tunes a trimmable on-chip RC oscillator against a reference clock. It runs a fixed-length successive-approximation search over a signed trim setting. On each step it turns the setting into a seven-nibble trim pattern and drives it to the oscillator. It then clears and preloads an external frequency-measurement counter with the target count and launches a measurement. When the measurement reports completion, the block reads back the count. It compares the count with the target and moves the setting down when too few edges were counted, or up when too many were counted.

The trim pattern is not a plain binary word. With `base = s / 7` and `rem = s % 7`, where `s` is the clamped setting, the low `rem + 1` nibbles carry `base` and the remaining nibbles carry `base - 1`, each truncated to four bits. After the last step, the block drives the final pattern with the oscillator enable set. One cycle later it raises the retention hold, so the trim survives power-down.

A host starts the search with a one-cycle `start_i` pulse and waits for `done_o`.

Top module: `osc_trim_cal`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o`, `osc_en_o`, `hold_o`, `meas_clr_o`, `meas_load_o` and `meas_start_o` are 0 and `trim_code_o` is 0.
- R2: Every measurement is preceded by a fixed three-cycle order: one cycle of `meas_clr_o`, then one cycle of `meas_load_o` with `meas_target_o` = 2048, then one cycle of `meas_start_o`. The three strobes are never high together.
- R3: While `meas_start_o` is high, `trim_code_o` holds the current setting encoded as seven 4-bit digits. Digit i occupies bits [4i+3:4i], with i = 0 as the least significant digit. Digit i carries `s/7` when i ≤ `s%7`, and `s/7 − 1` (mod 16) otherwise.
- R4: Before encoding, the signed setting is clamped to 0..112, so a negative setting is driven as setting 0.
- R5: After `meas_start_o`, the block first waits for `meas_done_i` to be low and only then for it to be high. A `meas_done_i` that is still high from the previous measurement is ignored.
- R6: With error = 2048 − `meas_count_i`, an error in −12..+12 leaves the setting unchanged for that step.
- R7: An error above +12 lowers the setting by half the current step. An error below −12 raises it by half the current step, where half means the step shifted right by one bit.
- R8: The search starts at setting 0 with step 56. After each measurement the step becomes (step + 1) >> 1. Exactly 8 measurements are made per calibration.
- R9: After the eighth measurement, `trim_code_o` shows the final encoded setting with `osc_en_o` = 1 one cycle before `hold_o` rises. `osc_en_o` is 0 during every measurement.
- R10: `busy_o` is high from the cycle after an accepted start until the hold is raised. At that point `done_o` pulses for one cycle with `busy_o` low. A `start_i` seen while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a calibration (accepted only when idle) |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle pulse when calibration completes |
| meas_clr_o | output | 1 | Measurement counter clear strobe |
| meas_load_o | output | 1 | Measurement counter preload strobe |
| meas_target_o | output | 16 | Preload / target count (2048) |
| meas_start_o | output | 1 | Measurement launch strobe |
| meas_done_i | input | 1 | Measurement finished |
| meas_count_i | input | 16 | Measured count, valid when `meas_done_i` rises |
| trim_code_o | output | 28 | Seven-nibble trim pattern to the oscillator |
| osc_en_o | output | 1 | Oscillator trim enable |
| hold_o | output | 1 | Retain trim across power-down |

## Verification
The hardest case to reach from the ports is a stale completion. `meas_done_i` is still high from the previous measurement when the next one is launched, and a block that skips the low phase would then act on the old count. The bench's measurement model deliberately holds `meas_done_i` high for two cycles after each launch. It keeps the previous count on `meas_count_i` until it raises completion with a new value, so any early sample changes the trajectory of settings the bench predicts. Directed counts sit exactly on and just outside the ±12 band edges and drive the setting negative to exercise the clamp. Random linear oscillator models with a seeded offset and slope cover the rest of the search.

// File: rtl/osc_trim_pkg.sv
// Shared types for the oscillator trim calibrator.
// Assumes: nothing beyond IEEE 1800-2017.
package osc_trim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_LOAD,
        ST_LAUNCH,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_FINAL,
        ST_SEAL
    } cal_state_e;

endpackage

// File: rtl/osc_trim_encoder.sv
// Clamps a signed trim setting to 0..MAX_SET and spreads it across DIGITS
// nibbles: the low (rem+1) digits carry base, the rest carry base-1.
// Assumes: SET_W is wide enough to hold MAX_SET as a positive signed value.
module osc_trim_encoder #(
    parameter int SET_W   = 9,
    parameter int MAX_SET = 112,
    parameter int DIGITS  = 7,
    parameter int DIG_W   = 4
) (
    input  logic signed [SET_W-1:0]        setting_i,
    output logic        [DIGITS*DIG_W-1:0] code_o
);

    logic [SET_W-1:0] clamped;
    logic [SET_W-1:0] base;
    logic [SET_W-1:0] base_m1;
    logic [SET_W-1:0] rem;

    // Saturate the signed setting into the legal trim range.
    always_comb begin
        if (setting_i < 0)
            clamped = '0;
        else if (setting_i > SET_W'(MAX_SET))
            clamped = SET_W'(MAX_SET);
        else
            clamped = setting_i;
    end

    // Split the clamped setting into quotient and remainder by DIGITS.
    always_comb begin
        base    = clamped / SET_W'(DIGITS);
        rem     = clamped % SET_W'(DIGITS);
        base_m1 = base - SET_W'(1);
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign code_o[g*DIG_W +: DIG_W] =
            (SET_W'(g) <= rem) ? base[DIG_W-1:0] : base_m1[DIG_W-1:0];
    end

endmodule

// File: rtl/osc_trim_stepper.sv
// One successive-approximation update: compares a measured count with the
// target and moves the setting by half the step when outside the band;
// also produces the next step, halved with round-up.
// Assumes: STEP_W < SET_W so half a step always fits the signed setting.
module osc_trim_stepper #(
    parameter int SET_W  = 9,
    parameter int STEP_W = 7,
    parameter int CNT_W  = 16,
    parameter int TARGET = 2048,
    parameter int BAND   = 12
) (
    input  logic signed [SET_W-1:0]  setting_i,
    input  logic        [STEP_W-1:0] step_i,
    input  logic        [CNT_W-1:0]  count_i,
    output logic signed [SET_W-1:0]  setting_o,
    output logic        [STEP_W-1:0] step_o
);

    localparam int DIFF_W = CNT_W + 2;

    logic signed [DIFF_W-1:0] err;
    logic signed [SET_W-1:0]  half;
    logic        [STEP_W:0]   step_inc;

    // Error and half-step, both as signed quantities.
    always_comb begin
        err  = $signed({2'b00, CNT_W'(TARGET)}) - $signed({2'b00, count_i});
        half = $signed(SET_W'(step_i >> 1));
    end

    // Move the setting only when the error leaves the tolerance band.
    always_comb begin
        if (err > DIFF_W'(BAND))
            setting_o = setting_i - half;
        else if (err < -DIFF_W'(BAND))
            setting_o = setting_i + half;
        else
            setting_o = setting_i;
    end

    // Halve the step, rounding up.
    always_comb begin
        step_inc = {1'b0, step_i} + (STEP_W+1)'(1);
        step_o   = step_inc[STEP_W:1];
    end

endmodule

// File: rtl/osc_trim_cal.sv
// Oscillator trim calibrator: runs ITERS measurement steps of a binary search
// over the trim setting, then writes the final code with enable and raises hold.
// Assumes: the measurement counter drops meas_done_i some cycles after
// meas_start_o and raises it again with meas_count_i valid.
module osc_trim_cal
    import osc_trim_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int TARGET  = 2048,
    parameter int BAND    = 12,
    parameter int DIGITS  = 7,
    parameter int DIG_W   = 4,
    parameter int MAX_SET = DIGITS * (1 << DIG_W),
    parameter int STEP0   = MAX_SET / 2,
    parameter int ITERS   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      meas_clr_o,
    output logic                      meas_load_o,
    output logic [CNT_W-1:0]          meas_target_o,
    output logic                      meas_start_o,
    input  logic                      meas_done_i,
    input  logic [CNT_W-1:0]          meas_count_i,
    output logic [DIGITS*DIG_W-1:0]   trim_code_o,
    output logic                      osc_en_o,
    output logic                      hold_o
);

    localparam int SET_W  = $clog2(MAX_SET + 1) + 2;
    localparam int STEP_W = $clog2(STEP0 + 1) + 1;
    localparam int IT_W   = $clog2(ITERS + 1);

    cal_state_e                state_q;
    logic signed [SET_W-1:0]   setting_q;
    logic signed [SET_W-1:0]   setting_nx;
    logic [STEP_W-1:0]         step_q;
    logic [STEP_W-1:0]         step_nx;
    logic [IT_W-1:0]           iter_q;
    logic [DIGITS*DIG_W-1:0]   code_now;

    osc_trim_encoder #(
        .SET_W(SET_W), .MAX_SET(MAX_SET), .DIGITS(DIGITS), .DIG_W(DIG_W)
    ) u_enc (
        .setting_i(setting_q),
        .code_o   (code_now)
    );

    osc_trim_stepper #(
        .SET_W(SET_W), .STEP_W(STEP_W), .CNT_W(CNT_W),
        .TARGET(TARGET), .BAND(BAND)
    ) u_step (
        .setting_i(setting_q),
        .step_i   (step_q),
        .count_i  (meas_count_i),
        .setting_o(setting_nx),
        .step_o   (step_nx)
    );

    // Measurement strobes and status decoded from the registered state.
    always_comb begin
        meas_clr_o    = (state_q == ST_CLR);
        meas_load_o   = (state_q == ST_LOAD);
        meas_start_o  = (state_q == ST_LAUNCH);
        busy_o        = (state_q != ST_IDLE);
        meas_target_o = CNT_W'(TARGET);
    end

    // Search sequencer: setup, launch, done handshake, update, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            setting_q   <= '0;
            step_q      <= '0;
            iter_q      <= '0;
            trim_code_o <= '0;
            osc_en_o    <= 1'b0;
            hold_o      <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        setting_q <= '0;
                        step_q    <= STEP_W'(STEP0);
                        iter_q    <= '0;
                        osc_en_o  <= 1'b0;
                        hold_o    <= 1'b0;
                        state_q   <= ST_CLR;
                    end
                end
                ST_CLR: begin
                    trim_code_o <= code_now;
                    state_q     <= ST_LOAD;
                end
                ST_LOAD:    state_q <= ST_LAUNCH;
                ST_LAUNCH:  state_q <= ST_WAIT_LO;
                ST_WAIT_LO: if (!meas_done_i) state_q <= ST_WAIT_HI;
                ST_WAIT_HI: begin
                    if (meas_done_i) begin
                        setting_q <= setting_nx;
                        step_q    <= step_nx;
                        iter_q    <= iter_q + IT_W'(1);
                        state_q   <= (iter_q == IT_W'(ITERS - 1)) ? ST_FINAL : ST_CLR;
                    end
                end
                ST_FINAL: begin
                    trim_code_o <= code_now;
                    osc_en_o    <= 1'b1;
                    state_q     <= ST_SEAL;
                end
                ST_SEAL: begin
                    hold_o  <= 1'b1;
                    done_o  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/osc_trim_cal_chk.sv
// Protocol checker for osc_trim_cal, attached by bind below.
// Assumes: synchronous active-low reset on rst_n.
module osc_trim_cal_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic meas_clr_o,
    input logic meas_load_o,
    input logic meas_start_o,
    input logic osc_en_o,
    input logic hold_o
);

    AST_LOAD_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        meas_load_o |-> $past(meas_clr_o)); // R2

    AST_LAUNCH_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start_o |-> $past(meas_load_o)); // R2

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({meas_clr_o, meas_load_o, meas_start_o})); // R2

    AST_HOLD_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(osc_en_o)); // R9

    AST_NO_ENABLE_IN_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start_o |-> !osc_en_o); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && hold_o)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

endmodule

bind osc_trim_cal osc_trim_cal_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .meas_clr_o  (meas_clr_o),
    .meas_load_o (meas_load_o),
    .meas_start_o(meas_start_o),
    .osc_en_o    (osc_en_o),
    .hold_o      (hold_o)
);

// File: tb/osc_trim_cal_tb_top.sv
// Self-checking bench: a behavioural measurement counter answers each launch
// with a stale-done window, then a count from a fixed or linear model.
module osc_trim_cal_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        meas_done_i = 1'b1;
    logic [15:0] meas_count_i = 16'd0;
    logic        busy_o, done_o, meas_clr_o, meas_load_o, meas_start_o;
    logic [15:0] meas_target_o;
    logic [27:0] trim_code_o;
    logic        osc_en_o, hold_o;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    osc_trim_cal dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o),
        .meas_clr_o(meas_clr_o), .meas_load_o(meas_load_o),
        .meas_target_o(meas_target_o), .meas_start_o(meas_start_o),
        .meas_done_i(meas_done_i), .meas_count_i(meas_count_i),
        .trim_code_o(trim_code_o), .osc_en_o(osc_en_o), .hold_o(hold_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Reference encoding with clamp (R3, R4).
    function automatic logic [27:0] ref_code(input int s);
        int c, b, m;
        logic [27:0] r;
        c = (s < 0) ? 0 : ((s > 112) ? 112 : s);
        b = c / 7;
        m = c % 7;
        r = '0;
        for (int i = 0; i < 7; i++)
            r[i*4 +: 4] = (i <= m) ? 4'(b) : 4'(b - 1);
        return r;
    endfunction

    // Measurement model: mode 0 fixed count, mode 1 linear in clamped setting.
    function automatic logic [15:0] model(input int mode, input int fixed_cnt,
                                          input int s0, input int slope, input int s);
        int c, v;
        c = (s < 0) ? 0 : ((s > 112) ? 112 : s);
        v = (mode == 0) ? fixed_cnt : 2048 + slope * (s0 - c);
        if (v < 0) v = 0;
        if (v > 65535) v = 65535;
        return 16'(v);
    endfunction

    task automatic run_cal(input int mode, input int fixed_cnt, input int s0, input int slope);
        int  mid, step, err, guard;
        logic [15:0] cnt;
        mid = 0;
        step = 56;
        tick();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
        chk(osc_en_o == 1'b0 && hold_o == 1'b0, "R9 enable/hold cleared", {osc_en_o, hold_o}, 0);
        for (int it = 0; it < 8; it++) begin
            guard = 0;
            while (!meas_clr_o && guard < 40) begin tick(); guard++; end
            chk(meas_clr_o == 1'b1, "R2 clear strobe", meas_clr_o, 1);
            chk(meas_load_o == 1'b0 && meas_start_o == 1'b0, "R2 strobes exclusive",
                {meas_load_o, meas_start_o}, 0);
            tick();
            chk(meas_load_o == 1'b1 && meas_target_o == 16'd2048, "R2 load strobe and target",
                {meas_load_o, meas_target_o}, {1'b1, 16'd2048});
            tick();
            chk(meas_start_o == 1'b1, "R2 launch strobe", meas_start_o, 1);
            chk(trim_code_o == ref_code(mid), (mid < 0) ? "R4 clamped code" : "R3 trim code",
                trim_code_o, ref_code(mid));
            // Stale done window (R5); a start here must be ignored (R10).
            if (it == 3) start_i = 1'b1;
            tick();
            start_i = 1'b0;
            tick();
            meas_done_i = 1'b0;
            repeat (1 + ($urandom % 4)) tick();
            cnt = model(mode, fixed_cnt, s0, slope, mid);
            meas_count_i = cnt;
            meas_done_i = 1'b1;
            // Expected update (R6, R7, R8).
            err = 2048 - int'(cnt);
            if (err > 12) mid = mid - step / 2;
            else if (err < -12) mid = mid + step / 2;
            step = (step + 1) / 2;
        end
        guard = 0;
        while (!osc_en_o && guard < 20) begin
            tick();
            guard++;
            if (meas_clr_o) chk(1'b0, "R8 extra measurement", 1, 0);
        end
        chk(osc_en_o == 1'b1 && hold_o == 1'b0, "R9 enable before hold", {osc_en_o, hold_o}, 2'b10);
        chk(trim_code_o == ref_code(mid), "R9 final code", trim_code_o, ref_code(mid));
        chk(busy_o == 1'b1, "R10 busy until hold", busy_o, 1);
        tick();
        chk(hold_o == 1'b1 && done_o == 1'b1 && busy_o == 1'b0, "R10 done pulse with hold",
            {hold_o, done_o, busy_o}, 3'b110);
        chk(osc_en_o == 1'b1 && trim_code_o == ref_code(mid), "R9 code retained",
            trim_code_o, ref_code(mid));
        tick();
        chk(done_o == 1'b0 && meas_clr_o == 1'b0, "R10 done single cycle, idle", {done_o, meas_clr_o}, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0a17));
        repeat (3) tick();
        chk(busy_o == 0 && done_o == 0 && osc_en_o == 0 && hold_o == 0, "R1 reset status",
            {busy_o, done_o, osc_en_o, hold_o}, 0);
        chk(meas_clr_o == 0 && meas_load_o == 0 && meas_start_o == 0 && trim_code_o == 0,
            "R1 reset strobes and code", trim_code_o, 0);
        rst_n = 1'b1;
        tick();
        // Directed band edges: R6 in band, R7 just outside, R4 clamp.
        run_cal(0, 2048, 0, 0);
        run_cal(0, 2060, 0, 0);
        run_cal(0, 2036, 0, 0);
        run_cal(0, 2035, 0, 0);
        run_cal(0, 2061, 0, 0);
        // Random linear oscillators.
        for (int k = 0; k < 12; k++)
            run_cal(1, 0, int'($urandom % 113), 1 + int'($urandom % 8));
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule